// File: doc/BRIEF.md
# SMM Memory Access Decoder

This block sorts every memory cycle seen by the host bridge against three system-management RAM windows. It decides, in the same cycle, whether the DRAM controller should claim the cycle or whether it should be forwarded to the PCI bus. The decision depends on who started the cycle (processor or bus master), whether the processor is in system-management mode, whether the access is a code fetch or a data access, and a small control register.

The three windows are a fixed legacy window just below 1 MB, a fixed high window just above 256 MB, and a top-segment window of selectable size that ends at 256 MB plus the top-of-memory value. A processor access from outside system-management mode that is not allowed into a window is sent to PCI, and a sticky violation flag records it. A lock bit freezes the configuration until reset.

Top module: `smm_access_decoder`

## Requirements
- R1: With the global enable (register bit 0) set, a valid cycle with an address from 0x000A0000 to 0x000BFFFF is a window hit.
- R2: A valid cycle with an address from 0x100A0000 to 0x100FFFFF is a window hit only when both bit 0 and the high-window enable (bit 1) are set.
- R3: The top-segment window covers 0x10000000 + tom - size up to, but not including, 0x10000000 + tom. Size field bits 4:3 select 0 = 128 KB, 1 = 256 KB, 2 = 512 KB, 3 = 1 MB. It is a hit only when bit 0 and the segment enable (bit 2) are set.
- R4: A valid cycle whose address lies in one of the three ranges but whose window is not enabled, including every range when bit 0 is clear, raises `pci_fwd`. An address outside all three ranges, or any cycle with `cyc_valid` low, raises neither strobe.
- R5: A bus-master cycle (`cyc_from_cpu` = 0) that hits a window raises `pci_fwd`, never `dram_claim`.
- R6: A processor cycle in system-management mode that hits a window raises `dram_claim`. The exception is when the close bit (bit 6) is set and the cycle is a data access (`cyc_code` = 0); that cycle raises `pci_fwd`. Code fetches still go to DRAM.
- R7: A processor cycle outside system-management mode that hits a window raises `dram_claim` only when the open bit (bit 5) is set and the lock bit (bit 7) is clear. Otherwise it raises `pci_fwd` and counts as a violation.
- R8: The violation flag (read as bit 8, output `viol_flag`) is set at the clock edge after a violating cycle. It stays set until a register write with bit 8 = 1 clears it. A violation in the same cycle as such a write keeps the flag set.
- R9: The lock bit can only be set, and clears only on reset. While it is set, the open bit reads 0, and writes to bits 0 to 5 have no effect. The close bit stays writable.
- R10: After reset every register bit reads 0 and no strobe is raised.
- R11: `dram_claim` and `pci_fwd` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 9 | Write data; bit 8 written as 1 clears the violation flag |
| reg_rdata | output | 9 | Register read value, with the violation flag in bit 8 |
| cyc_valid | input | 1 | A memory cycle is presented this clock |
| cyc_addr | input | ADDR_W | Cycle byte address |
| cyc_from_cpu | input | 1 | 1 = processor cycle, 0 = bus-master cycle |
| cyc_smm | input | 1 | Processor is in system-management mode |
| cyc_code | input | 1 | 1 = code fetch, 0 = data access |
| tom | input | TOM_W | Top of memory in bytes |
| dram_claim | output | 1 | DRAM claims the cycle (combinational) |
| pci_fwd | output | 1 | Cycle is forwarded to PCI (combinational) |
| viol_flag | output | 1 | Sticky violation status |

## Verification
The assertions assume that `cyc_from_cpu`, `cyc_smm` and `cyc_code` are meaningful only while `cyc_valid` is high. They also assume that `tom` is at least the largest segment size, so that the top-segment window never wraps below 256 MB. The stimulus keeps `tom` at 8 MB and drops `cyc_valid` between checked cycles. This keeps each violation tied to a single cycle, and the flag can be checked on the following edge. Register writes are issued on their own, apart from one deliberate write that overlaps a violation to show that setting the flag wins over clearing it.

// File: rtl/smm_dec_pkg.sv
// Package: shared constants and types for the SMM access decoder.
// Assumes byte addresses of at least 29 bits so the high windows fit.
package smm_dec_pkg;

    // register bit positions (software-visible layout)
    localparam int CFG_W     = 9;
    localparam int B_GEN     = 0;
    localparam int B_HEN     = 1;
    localparam int B_TEN     = 2;
    localparam int B_SZ_LO   = 3;
    localparam int B_OPEN    = 5;
    localparam int B_CLOSE   = 6;
    localparam int B_LOCK    = 7;
    localparam int B_VIOL    = 8;

    // window geometry
    localparam logic [31:0] LEG_LO   = 32'h000A_0000;
    localparam logic [31:0] LEG_HI   = 32'h000B_FFFF;
    localparam logic [31:0] HIGH_LO  = 32'h100A_0000;
    localparam logic [31:0] HIGH_HI  = 32'h100F_FFFF;
    localparam logic [31:0] TSEG_REF = 32'h1000_0000;
    localparam int          SEG_MIN_SHIFT = 17;   // 128 KB smallest segment
    localparam int          NUM_WIN  = 3;

    typedef struct packed {
        logic       lock;
        logic       close;
        logic       open;
        logic [1:0] sz;
        logic       ten;
        logic       hen;
        logic       gen;
    } smm_cfg_t;

    typedef enum logic [1:0] {
        RT_NONE = 2'd0,
        RT_DRAM = 2'd1,
        RT_PCI  = 2'd2
    } route_e;

endpackage

// File: rtl/smm_ctrl_reg.sv
// Module: control register and sticky violation flag.
// Lock is set-only; while locked, open reads 0 and enables/size are frozen.
// The violation flag is write-1-to-clear, and a new violation wins over a clear.
module smm_ctrl_reg
    import smm_dec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CFG_W-1:0] wdata,
    input  logic             viol_set,
    output smm_cfg_t         cfg,
    output logic             viol
);

    logic lock_next;

    // lock value after the current write
    always_comb lock_next = cfg.lock | wdata[B_LOCK];

    // configuration field update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr) begin
            if (!cfg.lock) begin
                cfg.gen <= wdata[B_GEN];
                cfg.hen <= wdata[B_HEN];
                cfg.ten <= wdata[B_TEN];
                cfg.sz  <= wdata[B_SZ_LO +: 2];
            end
            cfg.open  <= lock_next ? 1'b0 : wdata[B_OPEN];
            cfg.close <= wdata[B_CLOSE];
            cfg.lock  <= lock_next;
        end
    end

    // sticky violation flag, set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            viol <= 1'b0;
        else if (viol_set)
            viol <= 1'b1;
        else if (wr && wdata[B_VIOL])
            viol <= 1'b0;
    end

endmodule

// File: rtl/smm_window_match.sv
// Module: inclusive address range compare with an enable.
// in_range ignores the enable; hit requires it.
module smm_window_match #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] lo,
    input  logic [ADDR_W-1:0] hi,
    input  logic              en,
    output logic              in_range,
    output logic              hit
);

    // range test and enabled hit
    always_comb begin
        in_range = (addr >= lo) && (addr <= hi);
        hit      = in_range && en;
    end

endmodule

// File: rtl/smm_route.sv
// Module: routing decision for one cycle, given window results and control bits.
// Assumes at most a single cycle per clock; purely combinational.
module smm_route
    import smm_dec_pkg::*;
(
    input  logic     valid,
    input  logic     any_hit,
    input  logic     any_range,
    input  logic     from_cpu,
    input  logic     smm,
    input  logic     code,
    input  smm_cfg_t cfg,
    output route_e   route,
    output logic     viol_event
);

    // select the destination by initiator, mode and control bits
    always_comb begin
        route      = RT_NONE;
        viol_event = 1'b0;
        if (valid) begin
            if (any_hit) begin
                if (!from_cpu) begin
                    route = RT_PCI;
                end else if (smm) begin
                    route = (cfg.close && !code) ? RT_PCI : RT_DRAM;
                end else if (cfg.open && !cfg.lock) begin
                    route = RT_DRAM;
                end else begin
                    route      = RT_PCI;
                    viol_event = 1'b1;
                end
            end else if (any_range) begin
                route = RT_PCI;
            end
        end
    end

endmodule

// File: rtl/smm_access_decoder.sv
// Module: top of the SMM access decoder.
// Builds the three window bounds, matches the address, routes the cycle
// and holds the control register. Assumes tom >= the largest segment size.
module smm_access_decoder
    import smm_dec_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int TOM_W  = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [CFG_W-1:0]  reg_wdata,
    output logic [CFG_W-1:0]  reg_rdata,
    input  logic              cyc_valid,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic              cyc_from_cpu,
    input  logic              cyc_smm,
    input  logic              cyc_code,
    input  logic [TOM_W-1:0]  tom,
    output logic              dram_claim,
    output logic              pci_fwd,
    output logic              viol_flag
);

    localparam logic [ADDR_W-1:0] SEG_UNIT = ADDR_W'(1) << SEG_MIN_SHIFT;

    smm_cfg_t           cfg;
    logic               viol;
    logic               viol_event;
    route_e             route;
    logic [ADDR_W-1:0]  win_lo [NUM_WIN];
    logic [ADDR_W-1:0]  win_hi [NUM_WIN];
    logic [NUM_WIN-1:0] win_en;
    logic [NUM_WIN-1:0] win_in;
    logic [NUM_WIN-1:0] win_hit;
    logic [ADDR_W-1:0]  seg_size;
    logic [ADDR_W-1:0]  seg_end;

    // window bounds and enables
    always_comb begin
        seg_size  = SEG_UNIT << cfg.sz;
        seg_end   = ADDR_W'(TSEG_REF) + {{(ADDR_W-TOM_W){1'b0}}, tom};
        win_lo[0] = ADDR_W'(LEG_LO);
        win_hi[0] = ADDR_W'(LEG_HI);
        win_lo[1] = ADDR_W'(HIGH_LO);
        win_hi[1] = ADDR_W'(HIGH_HI);
        win_lo[2] = seg_end - seg_size;
        win_hi[2] = seg_end - ADDR_W'(1);
        win_en    = {cfg.gen & cfg.ten, cfg.gen & cfg.hen, cfg.gen};
    end

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        smm_window_match #(.ADDR_W(ADDR_W)) u_match (
            .addr     (cyc_addr),
            .lo       (win_lo[w]),
            .hi       (win_hi[w]),
            .en       (win_en[w]),
            .in_range (win_in[w]),
            .hit      (win_hit[w])
        );
    end

    smm_route u_route (
        .valid      (cyc_valid),
        .any_hit    (|win_hit),
        .any_range  (|win_in),
        .from_cpu   (cyc_from_cpu),
        .smm        (cyc_smm),
        .code       (cyc_code),
        .cfg        (cfg),
        .route      (route),
        .viol_event (viol_event)
    );

    smm_ctrl_reg u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .wdata    (reg_wdata),
        .viol_set (viol_event),
        .cfg      (cfg),
        .viol     (viol)
    );

    // output strobes and register read-back
    always_comb begin
        dram_claim = (route == RT_DRAM);
        pci_fwd    = (route == RT_PCI);
        viol_flag  = viol;
        reg_rdata  = {viol, cfg.lock, cfg.close, cfg.open, cfg.sz,
                      cfg.ten, cfg.hen, cfg.gen};
    end

endmodule

// File: rtl/smm_access_decoder_chk.sv
// Checker: port-level properties of the SMM access decoder, bound to the top.
module smm_access_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic [8:0] reg_wdata,
    input logic [8:0] reg_rdata,
    input logic       cyc_valid,
    input logic       cyc_from_cpu,
    input logic       cyc_smm,
    input logic       cyc_code,
    input logic       dram_claim,
    input logic       pci_fwd,
    input logic       viol_flag
);

    // R11
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dram_claim && pci_fwd));

    // R4
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_valid |-> !(dram_claim || pci_fwd));

    // R5
    master_no_dram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && !cyc_from_cpu) |-> !dram_claim);

    // R4
    gen_off_no_dram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[0] |-> !dram_claim);

    // R6
    close_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_from_cpu && cyc_smm && !cyc_code && reg_rdata[6])
        |-> !dram_claim);

    // R8
    viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_flag && !(reg_wr && reg_wdata[8])) |=> viol_flag);

    // R8
    viol_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!viol_flag && !(cyc_valid && cyc_from_cpu && !cyc_smm && pci_fwd))
        |=> !viol_flag);

    // R9
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[7] |=> reg_rdata[7]);

    // R9
    lock_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[7] |-> !reg_rdata[5]);

    // R9
    lock_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[7] |=> $stable(reg_rdata[4:0]));

endmodule

bind smm_access_decoder smm_access_decoder_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .cyc_valid    (cyc_valid),
    .cyc_from_cpu (cyc_from_cpu),
    .cyc_smm      (cyc_smm),
    .cyc_code     (cyc_code),
    .dram_claim   (dram_claim),
    .pci_fwd      (pci_fwd),
    .viol_flag    (viol_flag)
);

// File: tb/smm_access_decoder_tb.sv
// Bench: the driver pushes the expected strobe pair per cycle into a queue,
// and the monitor pops and compares a quarter period after the drive edge.
module smm_access_decoder_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [8:0]  reg_wdata = '0;
    logic [8:0]  reg_rdata;
    logic        cyc_valid = 1'b0;
    logic [31:0] cyc_addr = '0;
    logic        cyc_from_cpu = 1'b0;
    logic        cyc_smm = 1'b0;
    logic        cyc_code = 1'b0;
    logic [27:0] tom = 28'h080_0000;
    logic        dram_claim;
    logic        pci_fwd;
    logic        viol_flag;

    int total = 0;
    int bad = 0;

    typedef struct {
        logic       dram;
        logic       pci;
        string      req;
    } exp_t;

    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    smm_access_decoder u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr       (reg_wr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .cyc_valid    (cyc_valid),
        .cyc_addr     (cyc_addr),
        .cyc_from_cpu (cyc_from_cpu),
        .cyc_smm      (cyc_smm),
        .cyc_code     (cyc_code),
        .tom          (tom),
        .dram_claim   (dram_claim),
        .pci_fwd      (pci_fwd),
        .viol_flag    (viol_flag)
    );

    // monitor: compare strobes against the scoreboard queue
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                total++;
                if (dram_claim !== e.dram || pci_fwd !== e.pci) begin
                    bad++;
                    $display("FAIL %s addr=%h got dram=%b pci=%b exp dram=%b pci=%b",
                             e.req, cyc_addr, dram_claim, pci_fwd, e.dram, e.pci);
                end
            end
        end
    end

    // driver: present one cycle and push its expected routing
    task automatic drive(input logic [31:0] a, input logic cpu, input logic smm,
                         input logic code, input logic e_dram, input logic e_pci,
                         input string req);
        exp_t e;
        @(negedge clk);
        reg_wr       = 1'b0;
        cyc_valid    = 1'b1;
        cyc_addr     = a;
        cyc_from_cpu = cpu;
        cyc_smm      = smm;
        cyc_code     = code;
        e.dram = e_dram;
        e.pci  = e_pci;
        e.req  = req;
        sb_q.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        cyc_valid = 1'b0;
        reg_wr    = 1'b0;
    endtask

    task automatic wr(input logic [8:0] d);
        @(negedge clk);
        cyc_valid = 1'b0;
        reg_wr    = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] exp_v, input string req);
        #1;
        total++;
        if (act !== exp_v) begin
            bad++;
            $display("FAIL %s got %h exp %h", req, act, exp_v);
        end
    endtask

    // watchdog
    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // stimulus
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk({23'd0, reg_rdata}, 32'h0, "R10 rdata");
        chk({30'd0, dram_claim, pci_fwd}, 32'h0, "R10 strobes");

        // R4 global enable clear: window range goes to PCI
        drive(32'h000A_0000, 1, 1, 0, 0, 1, "R4 gen off");
        idle();

        // R1 legacy window
        wr(9'h001);
        drive(32'h000A_0000, 1, 1, 0, 1, 0, "R1 low edge");
        drive(32'h000B_FFFF, 1, 1, 0, 1, 0, "R1 high edge");
        drive(32'h000C_0000, 1, 1, 0, 0, 0, "R4 above legacy");
        drive(32'h0009_FFFF, 1, 1, 0, 0, 0, "R4 below legacy");
        // R2 high window disabled, then enabled
        drive(32'h100A_0000, 1, 1, 0, 0, 1, "R2 high disabled");
        idle();
        wr(9'h003);
        drive(32'h100A_0000, 1, 1, 0, 1, 0, "R2 high low edge");
        drive(32'h100F_FFFF, 1, 1, 0, 1, 0, "R2 high top edge");
        drive(32'h1010_0000, 1, 1, 0, 0, 0, "R4 above high");
        idle();

        // R3 top segment, 128 KB: 0x107E0000..0x107FFFFF
        wr(9'h005);
        drive(32'h107E_0000, 1, 1, 0, 1, 0, "R3 128K base");
        drive(32'h107F_FFFF, 1, 1, 0, 1, 0, "R3 128K top");
        drive(32'h107D_FFFF, 1, 1, 0, 0, 0, "R3 below 128K");
        drive(32'h1080_0000, 1, 1, 0, 0, 0, "R3 at end");
        idle();
        // R3 1 MB: 0x10700000..0x107FFFFF
        wr(9'h01D);
        drive(32'h1070_0000, 1, 1, 0, 1, 0, "R3 1M base");
        drive(32'h106F_FFFF, 1, 1, 0, 0, 0, "R3 below 1M");
        // R3 enable clear: range goes to PCI
        idle();
        wr(9'h019);
        drive(32'h1070_0000, 1, 1, 0, 0, 1, "R3 seg disabled");
        idle();

        // R5 bus master hit
        wr(9'h001);
        drive(32'h000A_8000, 0, 0, 0, 0, 1, "R5 master");
        drive(32'h000A_8000, 0, 1, 1, 0, 1, "R5 master smm");
        idle();

        // R6 close bit
        wr(9'h041);
        drive(32'h000A_1000, 1, 1, 0, 0, 1, "R6 close data");
        drive(32'h000A_1000, 1, 1, 1, 1, 0, "R6 close code");
        idle();
        wr(9'h001);
        drive(32'h000A_1000, 1, 1, 0, 1, 0, "R6 open data");
        idle();

        // R7 non-SMM with open clear: PCI and violation
        drive(32'h000A_2000, 1, 0, 0, 0, 1, "R7 no open");
        idle();
        chk({31'd0, viol_flag}, 32'h1, "R8 set");
        chk({23'd0, reg_rdata}, 32'h101, "R8 rdata");
        // R8 clear concurrent with new violation: stays set
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = 9'h101;
        cyc_valid = 1'b1; cyc_addr = 32'h000A_2000; cyc_from_cpu = 1'b1;
        cyc_smm = 1'b0; cyc_code = 1'b0;
        idle();
        chk({31'd0, viol_flag}, 32'h1, "R8 set wins");
        wr(9'h101);
        chk({31'd0, viol_flag}, 32'h0, "R8 w1c");
        // R7 open set: DRAM, no violation
        wr(9'h021);
        drive(32'h000A_2000, 1, 0, 0, 1, 0, "R7 open");
        idle();
        chk({31'd0, viol_flag}, 32'h0, "R7 no viol");

        // R9 lock: open forced clear
        wr(9'h0A1);
        chk({23'd0, reg_rdata}, 32'h081, "R9 lock set");
        drive(32'h000A_2000, 1, 0, 0, 0, 1, "R9 locked non-smm");
        idle();
        chk({31'd0, viol_flag}, 32'h1, "R9 locked viol");
        wr(9'h100);
        chk({23'd0, reg_rdata}, 32'h081, "R9 lock hold");
        wr(9'h03E);
        chk({23'd0, reg_rdata}, 32'h081, "R9 fields frozen");
        wr(9'h040);
        chk({23'd0, reg_rdata}, 32'h0C1, "R9 close writable");
        drive(32'h000A_2000, 1, 1, 1, 1, 0, "R9 smm code locked");

        idle();
        repeat (2) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule